// File: doc/BRIEF.md
# PCI Clock Stop Gate with Register Override

This block drives a group of single-ended PCI clock outputs from a free-running PCI clock waveform. The waveform is built inside the block from a faster reference clock. Each period is `PERIOD` reference cycles long, and the first `HIGH_LEN` cycles of each period are the high phase.

Two sources can halt the stoppable outputs:
- an external active-low stop pin, which is asynchronous and is synchronized into the reference clock domain;
- a one-bit run control register, written through a simple write strobe.

The two sources are combined so that either one can stop the clocks. The register read port returns the combined run state, not the value that was written. A read of 1 means the stoppable clocks are running. A read of 0 means that one of the sources has stopped them.

There are two output classes. Plain PCI outputs always obey the stop request. The free-running-class outputs each have an enable bit. When that bit is set, the output ignores the stop request. When it is clear, the output behaves like a plain one.

Stopped outputs rest low. The decision to run or stop a lane is taken only at the last low cycle of a period. As a result, every high phase that appears is a whole high phase, both on entering a stop and on leaving it.

Top module: `pci_clk_stop`

## Requirements
- R1: While `rst_n` is low, all outputs in `pci_out` and `pcif_out` are 0 and `reg_rd_bit` is 0.
- R2: While running, every output repeats with a period of `PERIOD` reference cycles. Each period is high for the first `HIGH_LEN` cycles and low for the rest, and all running outputs are in phase.
- R3: When `stop_pin_n` is held at 0, every `pci_out` bit is 0 from no later than 2*`PERIOD` reference cycles after the pin fell, for as long as the stop lasts.
- R4: Writing 0 to the run bit (`reg_wr_en`=1, `reg_wr_bit`=0) stops the stoppable outputs exactly as the pin does. Writing 1 lets them run only while `stop_pin_n` is 1.
- R5: `reg_rd_bit` is 1 only when the synchronized pin is 1 and the run bit is 1. It reads 0 whenever either source is 0, including after a written 1.
- R6: A `pcif_out[i]` whose `free_run_en[i]` is 1 keeps toggling through any stop. A `pcif_out[i]` whose `free_run_en[i]` is 0 stops together with `pci_out`.
- R7: After the last stop source is released, the stopped outputs show their first high phase no later than 2*`PERIOD` reference cycles after the release.
- R8: Every high phase on any output lasts exactly `HIGH_LEN` reference cycles, whatever the phase at which a stop is requested, released or a free-run bit is changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the PCI waveform is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_pin_n | input | 1 | Asynchronous active-low external stop request |
| reg_wr_en | input | 1 | Write strobe for the run control bit |
| reg_wr_bit | input | 1 | Value written to the run control bit (0 = stop) |
| reg_rd_bit | output | 1 | Combined run state readback (1 = stoppable clocks running) |
| free_run_en | input | NUM_PCIF | Per-lane free-run enable for the F-class outputs |
| pci_out | output | NUM_PCI | Gated plain PCI clock outputs |
| pcif_out | output | NUM_PCIF | Gated F-class PCI clock outputs |

## Verification
The stop function is driven from the pin alone, from the register alone, and from both at once. This shows that the two sources are combined as an OR of stops, and that the readback reports the combined state rather than the written value. A free-run mask with one lane set and one lane clear tells the free-running class apart from the stoppable class during the same stop. The pin is also asserted and released at each of the `PERIOD` phase offsets while a pulse monitor measures every high phase. This shows that no phase alignment of the request can produce a shortened or stretched pulse, and that the restart latency stays within two periods.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Counter value that follows cnt in a period of the given length
  function automatic int next_count(int cnt, int period);
    return (cnt == period - 1) ? 0 : cnt + 1;
  endfunction

  // True on the last low cycle of a period, where run decisions are taken
  function automatic logic is_boundary(int cnt, int period);
    return cnt == period - 1;
  endfunction

  // Reference waveform level for a given phase count
  function automatic logic phase_is_high(int cnt, int high_len);
    return cnt < high_len;
  endfunction

  // Run decision of one lane at a boundary
  function automatic logic lane_runs(logic stop_req, logic stoppable);
    return !(stop_req && stoppable);
  endfunction

endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RESET_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_async};
    end
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pcs_phase_gen.sv
module pcs_phase_gen
  import pcs_pkg::*;
#(
  parameter int PERIOD   = 8,
  parameter int HIGH_LEN = 4,
  localparam int CW      = $clog2(PERIOD)
) (
  input  logic clk,
  input  logic rst_n,
  output logic boundary,
  output logic hi_next,
  output logic ref_q
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign cnt_d    = CW'(next_count(int'(cnt_q), PERIOD));
  assign boundary = is_boundary(int'(cnt_q), PERIOD);
  assign hi_next  = phase_is_high(int'(cnt_d), HIGH_LEN);

  // Reset parks the counter on a boundary, so the first edge begins a whole period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(PERIOD - 1);
      ref_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ref_q <= hi_next;
    end
  end

endmodule

// File: rtl/pcs_ctrl.sv
module pcs_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_run_sync,
  input  logic wr_en,
  input  logic wr_bit,
  output logic stop_req,
  output logic rd_bit
);

  logic run_bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_bit_q <= 1'b1;
    end else if (wr_en) begin
      run_bit_q <= wr_bit;
    end
  end

  // Either source at 0 stops the stoppable clocks
  assign stop_req = !(pin_run_sync && run_bit_q);
  assign rd_bit   = !stop_req;

endmodule

// File: rtl/pcs_lane.sv
module pcs_lane
  import pcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic hi_next,
  input  logic stop_req,
  input  logic stoppable,
  output logic out_q
);

  logic run_q;
  logic run_d;

  assign run_d = boundary ? lane_runs(stop_req, stoppable) : run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      run_q <= run_d;
      out_q <= hi_next & run_d;
    end
  end

endmodule

// File: rtl/pci_clk_stop.sv
module pci_clk_stop #(
  parameter int NUM_PCI     = 4,
  parameter int NUM_PCIF    = 2,
  parameter int PERIOD      = 8,
  parameter int HIGH_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_pin_n,
  input  logic                reg_wr_en,
  input  logic                reg_wr_bit,
  output logic                reg_rd_bit,
  input  logic [NUM_PCIF-1:0] free_run_en,
  output logic [NUM_PCI-1:0]  pci_out,
  output logic [NUM_PCIF-1:0] pcif_out
);

  // Named internal events, brought out for the checker
  logic boundary_w;
  logic hi_next_w;
  logic ref_w;
  logic pin_run_w;
  logic stop_req_w;

  pcs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(stop_pin_n), .q_sync(pin_run_w)
  );

  pcs_phase_gen #(.PERIOD(PERIOD), .HIGH_LEN(HIGH_LEN)) u_phase (
    .clk(clk), .rst_n(rst_n), .boundary(boundary_w), .hi_next(hi_next_w), .ref_q(ref_w)
  );

  pcs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_run_sync(pin_run_w), .wr_en(reg_wr_en),
    .wr_bit(reg_wr_bit), .stop_req(stop_req_w), .rd_bit(reg_rd_bit)
  );

  for (genvar i = 0; i < NUM_PCI; i++) begin : g_pci
    pcs_lane u_lane (
      .clk(clk), .rst_n(rst_n), .boundary(boundary_w), .hi_next(hi_next_w),
      .stop_req(stop_req_w), .stoppable(1'b1), .out_q(pci_out[i])
    );
  end

  for (genvar j = 0; j < NUM_PCIF; j++) begin : g_pcif
    pcs_lane u_lane (
      .clk(clk), .rst_n(rst_n), .boundary(boundary_w), .hi_next(hi_next_w),
      .stop_req(stop_req_w), .stoppable(!free_run_en[j]), .out_q(pcif_out[j])
    );
  end

endmodule

// File: rtl/pci_clk_stop_chk.sv
module pci_clk_stop_chk #(
  parameter int NUM_PCI  = 4,
  parameter int NUM_PCIF = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr_en,
  input logic                reg_wr_bit,
  input logic                reg_rd_bit,
  input logic [NUM_PCIF-1:0] free_run_en,
  input logic [NUM_PCI-1:0]  pci_out,
  input logic [NUM_PCIF-1:0] pcif_out,
  input logic                boundary_w,
  input logic                stop_req_w,
  input logic                ref_w
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (pci_out == '0 && pcif_out == '0 && !reg_rd_bit);
    end
  end

  assert_wr_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !reg_wr_bit) |=> !reg_rd_bit);

  for (genvar i = 0; i < NUM_PCI; i++) begin : g_pci_chk
    assert_under_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pci_out[i] |-> ref_w);
    assert_rise_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pci_out[i]) |-> $rose(ref_w));
    assert_stop_applied_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_w && stop_req_w) |=> !pci_out[i]);
    assert_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_w && !stop_req_w) |=> pci_out[i]);
  end

  for (genvar j = 0; j < NUM_PCIF; j++) begin : g_pcif_chk
    assert_free_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_w && free_run_en[j]) |=> pcif_out[j]);
    assert_f_rise_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pcif_out[j]) |-> $rose(ref_w));
  end

endmodule

bind pci_clk_stop pci_clk_stop_chk #(.NUM_PCI(NUM_PCI), .NUM_PCIF(NUM_PCIF)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_bit(reg_wr_bit),
  .reg_rd_bit(reg_rd_bit), .free_run_en(free_run_en), .pci_out(pci_out),
  .pcif_out(pcif_out), .boundary_w(boundary_w), .stop_req_w(stop_req_w), .ref_w(ref_w)
);

// File: tb/sim_pci_clk_stop.sv
module sim_pci_clk_stop;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NF = 2;
  localparam int P  = 8;
  localparam int HL = 4;
  localparam int NL = NP + NF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_pin_n = 1'b1;
  logic reg_wr_en = 1'b0;
  logic reg_wr_bit = 1'b1;
  logic reg_rd_bit;
  logic [NF-1:0] free_run_en = '0;
  logic [NP-1:0] pci_out;
  logic [NF-1:0] pcif_out;

  int checks = 0;
  int errors = 0;
  int mon_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_clk_stop #(.NUM_PCI(NP), .NUM_PCIF(NF), .PERIOD(P), .HIGH_LEN(HL)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_pin_n(stop_pin_n), .reg_wr_en(reg_wr_en),
    .reg_wr_bit(reg_wr_bit), .reg_rd_bit(reg_rd_bit), .free_run_en(free_run_en),
    .pci_out(pci_out), .pcif_out(pcif_out)
  );

  // Pulse-width monitor for R8: every completed high phase must be HL cycles
  int run_len [NL];
  logic [NL-1:0] prev_lvl = '0;
  always @(negedge clk) begin
    logic [NL-1:0] lvl;
    lvl = {pcif_out, pci_out};
    if (rst_n) begin
      for (int k = 0; k < NL; k++) begin
        if (lvl[k]) run_len[k] = run_len[k] + 1;
        else if (prev_lvl[k]) begin
          if (run_len[k] != HL) mon_bad++;
          run_len[k] = 0;
        end
      end
    end else begin
      for (int k = 0; k < NL; k++) run_len[k] = 0;
    end
    prev_lvl = lvl;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_run(input logic v);
    reg_wr_en = 1'b1; reg_wr_bit = v;
    cyc(1);
    reg_wr_en = 1'b0;
  endtask

  // High cycles seen on one lane over one period
  task automatic highs_in_period(input int lane, output int n);
    n = 0;
    for (int c = 0; c < P; c++) begin
      @(negedge clk);
      if ({pcif_out, pci_out}[lane]) n++;
    end
  endtask

  task automatic test_reset;
    cyc(3);
    check("R1 pci low in reset", int'(pci_out), 0);
    check("R1 pcif low in reset", int'(pcif_out), 0);
    check("R1 readback 0 in reset", int'(reg_rd_bit), 0);
    rst_n = 1'b1;
  endtask

  task automatic test_running;
    int t_rise;
    int t_fall;
    int t_next;
    int n;
    cyc(2*P);
    n = 0;
    while (!pci_out[0] && n < 2*P) begin cyc(1); n++; end
    while (pci_out[0] && n < 4*P) begin cyc(1); n++; end
    t_rise = 0;
    while (!pci_out[0] && t_rise < 2*P) begin cyc(1); t_rise++; end
    check("R2 all lanes in phase", int'({pcif_out, pci_out}), (1 << NL) - 1);
    t_fall = 0;
    while (pci_out[0] && t_fall < 2*P) begin cyc(1); t_fall++; end
    t_next = 0;
    while (!pci_out[0] && t_next < 2*P) begin cyc(1); t_next++; end
    check("R2 high length", t_fall, HL);
    check("R2 period", t_fall + t_next, P);
    check("R5 readback 1 when running", int'(reg_rd_bit), 1);
  endtask

  task automatic test_pin_stop;
    int n0;
    int n1;
    int lat;
    free_run_en = 2'b01;
    stop_pin_n = 1'b0;
    cyc(2*P);
    check("R3 pci low after pin stop", int'(pci_out), 0);
    check("R5 readback 0 on pin stop", int'(reg_rd_bit), 0);
    highs_in_period(NP, n0);
    highs_in_period(NP + 1, n1);
    check("R3 pci still low", int'(pci_out), 0);
    check("R6 free lane toggles in stop", n0, HL);
    check("R6 stoppable F lane stopped", n1, 0);
    stop_pin_n = 1'b1;
    lat = 0;
    while (!pci_out[0] && lat < 4*P) begin cyc(1); lat++; end
    check("R7 resume latency within 2 periods", int'(lat <= 2*P), 1);
    check("R6 stoppable F lane resumes", int'(pcif_out[1]), 1);
    free_run_en = 2'b00;
  endtask

  task automatic test_reg_stop;
    int lat;
    write_run(1'b0);
    check("R4 R5 readback 0 after write 0", int'(reg_rd_bit), 0);
    cyc(2*P);
    check("R4 pci low on register stop", int'(pci_out), 0);
    check("R4 F lane low on register stop", int'(pcif_out), 0);
    write_run(1'b1);
    check("R5 readback 1 after write 1", int'(reg_rd_bit), 1);
    lat = 0;
    while (!pci_out[0] && lat < 4*P) begin cyc(1); lat++; end
    check("R7 resume after register release", int'(lat <= 2*P), 1);
    // pin low with run bit 1: readback reports the combined state
    stop_pin_n = 1'b0;
    cyc(3);
    write_run(1'b1);
    check("R5 readback 0 despite written 1", int'(reg_rd_bit), 0);
    cyc(2*P);
    check("R4 written 1 cannot override pin", int'(pci_out), 0);
    // register stop holds after the pin is released
    write_run(1'b0);
    stop_pin_n = 1'b1;
    cyc(3*P);
    check("R4 register keeps clocks stopped", int'(pci_out), 0);
    check("R5 readback 0 with register stop", int'(reg_rd_bit), 0);
    write_run(1'b1);
    cyc(2*P);
  endtask

  task automatic test_offsets;
    int lat;
    for (int off = 0; off < P; off++) begin
      cyc(off);
      stop_pin_n = 1'b0;
      cyc(2*P);
      check("R3 stopped at offset", int'(pci_out), 0);
      cyc(off);
      stop_pin_n = 1'b1;
      lat = 0;
      while (!pci_out[0] && lat < 4*P) begin cyc(1); lat++; end
      check("R7 resume latency at offset", int'(lat <= 2*P), 1);
      cyc(P + 3);
    end
    for (int off = 0; off < P; off++) begin
      cyc(off);
      free_run_en = ~free_run_en;
      stop_pin_n = ~stop_pin_n;
      cyc(P + 1);
    end
    stop_pin_n = 1'b1;
    free_run_en = '0;
    cyc(3*P);
    check("R8 no partial high phase", mon_bad, 0);
  endtask

  initial begin
    test_reset;
    test_running;
    test_pin_stop;
    test_reg_stop;
    test_offsets;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule